// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer that software controls through a small register bus. A 12-bit down-counter is decremented by ticks from a programmable power-of-two prescaler. If software does not refresh the counter before it runs out, the block raises a one-cycle reset request, reloads the counter and begins another timeout period.

Software controls the block only by writing 16-bit magic values to a key register. One key starts the watchdog, one refreshes the counter, and one opens the prescaler and reload registers for writing. Any other key value closes those registers again.

A new prescaler or reload value is visible on readback at once. The counting logic uses it only after a fixed settling delay. Two status bits show when such an update is still in flight. Once started, the watchdog cannot be stopped by software. Only the block reset stops it.

Top module: `key_wdog`

## Requirements
- R1: After reset, the registers read as follows:
  - the divider code (offset 0x04, bits 2:0) reads 0;
  - the reload value (offset 0x08, bits 11:0) reads 0xFFF;
  - the status register (offset 0x0C) reads 0;
  - `rst_req_o` is low.

  While the watchdog has not been started, no reset request is ever raised.
- R2: Writing 0x5555 to the key register (offset 0x00) opens the divider code and reload registers. A write to either register while it is open takes effect on readback from the next cycle.
- R3: The divider code and reload registers are closed in two cases:
  - after reset;
  - after any key write other than 0x5555 (for example 0x0000, 0xAAAA or 0x1234).

  While they are closed, writes to them leave their readback unchanged.
- R4: An accepted write to a configuration register sets a status bit:
  - a divider code write sets status bit 0;
  - a reload write sets status bit 1.

  The bit reads 1 from the cycle after the write for SYNC_CYCLES (3) cycles, then reads 0. Only from that point does the counting logic use the new value.
- R5: Writing 0xCCCC to the key register starts the watchdog. It loads the counter with the applied reload value R and restarts the prescaler. The first reset request is seen exactly (R+1)·4·2^code clock cycles after the cycle in which the key was written.
- R6: Once the watchdog is running, writing 0xAAAA to the key register reloads the counter from R and restarts the prescaler. Refreshes spaced closer than the timeout period keep `rst_req_o` low. After the last refresh, the request follows after exactly one full period.
- R7: A reset request lasts one cycle. The counter then reloads on its own, and the next request follows exactly one full period later.
- R8: Once started, the watchdog keeps running whatever keys are written later.
- R9: A 0xAAAA key written before the watchdog is started raises no reset request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock, also the counting clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_sel_i | input | 1 | Register access select |
| bus_we_i | input | 1 | Write strobe, qualified by bus_sel_i |
| bus_addr_i | input | 5 | Byte offset of the register |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for bus_addr_i, combinational |
| rst_req_o | output | 1 | One-cycle reset request on timeout |

## Verification
A wrong counter or prescaler state shows up at `rst_req_o` as a request that is early, late or missing. It shows no later than one timeout period after the last start or refresh key, so each timing check compares the cycle count to the expected period exactly. A wrong lock or pending-flag state shows up on the very next register read, as a changed readback or a status bit with the wrong value. An applied value that takes effect too soon or too late shows in the first period timed after the update.

// File: rtl/key_wdog_pkg.sv
package key_wdog_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFS_KEY    = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_DIV    = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_RELOAD = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 5'h0C;

  localparam logic [DATA_W-1:0] KEY_REFRESH = 16'hAAAA;
  localparam logic [DATA_W-1:0] KEY_START   = 16'hCCCC;
  localparam logic [DATA_W-1:0] KEY_OPEN    = 16'h5555;
endpackage

// File: rtl/wdog_key_ctrl.sv
module wdog_key_ctrl
  import key_wdog_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              key_wr_i,
  input  logic [DATA_W-1:0] key_i,
  output logic              open_o,
  output logic              running_o,
  output logic              start_o,
  output logic              refresh_o
);
  logic open_q, run_q;

  assign start_o   = key_wr_i && (key_i == KEY_START) && !run_q;
  assign refresh_o = key_wr_i && (key_i == KEY_REFRESH) && run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      if (key_wr_i) open_q <= (key_i == KEY_OPEN);
      if (start_o)  run_q  <= 1'b1;
    end
  end

  assign open_o    = open_q;
  assign running_o = run_q;

  AST_RUN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |=> run_q); // R8
  AST_OPEN_BY_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_q) |-> $past(key_wr_i && key_i == KEY_OPEN)); // R2
endmodule

// File: rtl/wdog_cfg_reg.sv
module wdog_cfg_reg #(
  parameter int         W           = 12,
  parameter int         SYNC_CYCLES = 3,
  parameter logic [W-1:0] RST_VAL   = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] value_o,
  output logic [W-1:0] applied_o,
  output logic         pending_o
);
  localparam int SC_W = $clog2(SYNC_CYCLES + 1);
  localparam logic [SC_W-1:0] SC_INIT = SC_W'(SYNC_CYCLES);

  logic [W-1:0]    value_q, applied_q;
  logic [SC_W-1:0] sc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      value_q   <= RST_VAL;
      applied_q <= RST_VAL;
      sc_q      <= '0;
    end else if (wr_i) begin
      value_q <= wdata_i;
      sc_q    <= SC_INIT;
    end else if (sc_q != '0) begin
      sc_q <= sc_q - 1'b1;
      if (sc_q == SC_W'(1)) applied_q <= value_q;
    end
  end

  assign value_o   = value_q;
  assign applied_o = applied_q;
  assign pending_o = (sc_q != '0);

  AST_PEND_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> pending_o); // R4
  AST_APPLY_ON_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pending_o) |-> applied_o == value_o); // R4
endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int CODE_W    = 3,
  parameter int BASE_LOG2 = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              restart_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              tick_o
);
  localparam int CNT_W = BASE_LOG2 + (2**CODE_W) - 1;

  logic [CNT_W-1:0] cnt_q, lim;

  // divide ratio 2^(BASE_LOG2+code); lim = ratio-1
  assign lim    = {CNT_W{1'b1}} >> (CNT_W - BASE_LOG2 - int'(code_i));
  assign tick_o = run_i && (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (tick_o)    cnt_q <= '0;
    else if (run_i)     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdog_down_counter.sv
module wdog_down_counter #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         run_i,
  input  logic         tick_i,
  output logic         req_o
);
  logic [W-1:0] cnt_q;
  logic         req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '1;
      req_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
      req_q <= 1'b0;
    end else if (run_i && tick_i) begin
      if (cnt_q == '0) begin
        cnt_q <= load_val_i;
        req_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
        req_q <= 1'b0;
      end
    end else begin
      req_q <= 1'b0;
    end
  end

  assign req_o = req_q;

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |=> !req_q); // R7
  AST_NO_REQ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !req_q); // R1
  AST_CNT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i)); // R6
endmodule

// File: rtl/key_wdog.sv
module key_wdog
  import key_wdog_pkg::*;
#(
  parameter int CODE_W      = 3,
  parameter int RELOAD_W    = 12,
  parameter int BASE_LOG2   = 2,
  parameter int SYNC_CYCLES = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              rst_req_o
);
  logic wr, open, running, start, refresh, tick;
  logic div_wr, rl_wr, div_pend, rl_pend;
  logic [CODE_W-1:0]   div_val, div_app;
  logic [RELOAD_W-1:0] rl_val, rl_app;

  assign wr     = bus_sel_i && bus_we_i;
  assign div_wr = wr && open && (bus_addr_i == OFS_DIV);
  assign rl_wr  = wr && open && (bus_addr_i == OFS_RELOAD);

  wdog_key_ctrl u_key (
    .clk_i, .rst_ni,
    .key_wr_i (wr && (bus_addr_i == OFS_KEY)),
    .key_i    (bus_wdata_i),
    .open_o   (open),
    .running_o(running),
    .start_o  (start),
    .refresh_o(refresh)
  );

  wdog_cfg_reg #(.W(CODE_W), .SYNC_CYCLES(SYNC_CYCLES), .RST_VAL('0)) u_div (
    .clk_i, .rst_ni,
    .wr_i(div_wr), .wdata_i(bus_wdata_i[CODE_W-1:0]),
    .value_o(div_val), .applied_o(div_app), .pending_o(div_pend)
  );

  wdog_cfg_reg #(.W(RELOAD_W), .SYNC_CYCLES(SYNC_CYCLES), .RST_VAL('1)) u_rl (
    .clk_i, .rst_ni,
    .wr_i(rl_wr), .wdata_i(bus_wdata_i[RELOAD_W-1:0]),
    .value_o(rl_val), .applied_o(rl_app), .pending_o(rl_pend)
  );

  wdog_prescaler #(.CODE_W(CODE_W), .BASE_LOG2(BASE_LOG2)) u_pre (
    .clk_i, .rst_ni,
    .run_i(running), .restart_i(start || refresh),
    .code_i(div_app), .tick_o(tick)
  );

  wdog_down_counter #(.W(RELOAD_W)) u_cnt (
    .clk_i, .rst_ni,
    .load_i(start || refresh), .load_val_i(rl_app),
    .run_i(running), .tick_i(tick), .req_o(rst_req_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      OFS_DIV:    bus_rdata_o[CODE_W-1:0]   = div_val;
      OFS_RELOAD: bus_rdata_o[RELOAD_W-1:0] = rl_val;
      OFS_STATUS: bus_rdata_o[1:0]          = {rl_pend, div_pend};
      default:    bus_rdata_o = '0;
    endcase
  end

  AST_CLOSED_DIV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && !open && bus_addr_i == OFS_DIV) |=> $stable(div_val)); // R3
  AST_CLOSED_RL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && !open && bus_addr_i == OFS_RELOAD) |=> $stable(rl_val)); // R3
endmodule

// File: tb/key_wdog_tb_top.sv
module key_wdog_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_sel_i = 1'b0, bus_we_i = 1'b0;
  logic [4:0]  bus_addr_i = '0;
  logic [15:0] bus_wdata_i = '0;
  logic [15:0] bus_rdata_o;
  logic        rst_req_o;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  key_wdog dut_i (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [15:0] d);
    bus_sel_i = 1; bus_we_i = 1; bus_addr_i = a; bus_wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    bus_sel_i = 0; bus_we_i = 0;
  endtask

  task automatic read_chk(input logic [4:0] a, input int exp, input string req);
    bus_addr_i = a;
    #1;
    check(bus_rdata_o == 16'(exp), req, int'(bus_rdata_o), exp);
  endtask

  task automatic cycles(input int k);
    repeat (k) @(negedge clk_i);
  endtask

  // posedges counted until rst_req_o seen at a negedge; 0 if not within limit
  task automatic wait_req(input int limit, output int n);
    n = 0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk_i);
      if (rst_req_o) begin n = i; break; end
    end
  endtask

  task automatic t_reset;
    read_chk(5'h04, 0, "R1 div reset");
    read_chk(5'h08, 12'hFFF, "R1 reload reset");
    read_chk(5'h0C, 0, "R1 status reset");
    check(rst_req_o == 0, "R1 req reset", int'(rst_req_o), 0);
  endtask

  task automatic t_closed;
    bus_write(5'h04, 16'h0005);
    read_chk(5'h04, 0, "R3 closed div write after reset");
    read_chk(5'h0C, 0, "R3 no pending on closed write");
  endtask

  task automatic t_open_pending;
    bus_write(5'h00, 16'h5555);
    bus_write(5'h04, 16'h0001);
    read_chk(5'h04, 1, "R2 div readback");
    read_chk(5'h0C, 1, "R4 div pending set");
    cycles(2);
    read_chk(5'h0C, 1, "R4 div pending held");
    cycles(1);
    read_chk(5'h0C, 0, "R4 div pending clear");
    bus_write(5'h08, 16'h0003);
    read_chk(5'h08, 3, "R2 reload readback");
    read_chk(5'h0C, 2, "R4 reload pending set");
    cycles(2);
    read_chk(5'h0C, 2, "R4 reload pending held");
    cycles(1);
    read_chk(5'h0C, 0, "R4 reload pending clear");
  endtask

  task automatic t_relock;
    bus_write(5'h00, 16'h0000);
    bus_write(5'h08, 16'h0123);
    read_chk(5'h08, 3, "R3 closed by 0x0000");
    bus_write(5'h00, 16'h5555);
    bus_write(5'h00, 16'h1234);
    bus_write(5'h04, 16'h0006);
    read_chk(5'h04, 1, "R3 closed by other key");
  endtask

  task automatic t_refresh_idle;
    int n;
    bus_write(5'h00, 16'hAAAA);
    wait_req(200, n);
    check(n == 0, "R9 no request before start", n, 0);
  endtask

  task automatic t_start_period;
    int n;
    bus_write(5'h00, 16'hCCCC);
    wait_req(100, n);
    check(n == 32, "R5 first timeout (3+1)*8", n, 32);
    @(negedge clk_i);
    check(rst_req_o == 0, "R7 request one cycle", int'(rst_req_o), 0);
    wait_req(100, n);
    check(n == 31, "R7 next period", n + 1, 32);
  endtask

  task automatic t_refresh_run;
    int n, seen;
    seen = 0;
    for (int k = 0; k < 10; k++) begin
      bus_write(5'h00, 16'hAAAA);
      for (int c = 0; c < 19; c++) begin
        @(negedge clk_i);
        if (rst_req_o) seen++;
      end
    end
    check(seen == 0, "R6 refresh keeps request low", seen, 0);
    bus_write(5'h00, 16'hAAAA);
    wait_req(100, n);
    check(n == 32, "R6 period after last refresh", n, 32);
  endtask

  task automatic t_sticky;
    int n;
    bus_write(5'h00, 16'h0000);
    bus_write(5'h00, 16'h5555);
    bus_write(5'h00, 16'h0000);
    wait_req(64, n);
    check(n > 0 && n <= 32, "R8 still running after keys", n, 32);
  endtask

  task automatic t_new_values;
    int n;
    bus_write(5'h00, 16'h5555);
    bus_write(5'h08, 16'h0001);
    cycles(4);
    bus_write(5'h00, 16'hAAAA);
    wait_req(100, n);
    check(n == 16, "R4 applied reload 1 -> 16", n, 16);
    bus_write(5'h00, 16'h5555);
    bus_write(5'h04, 16'h0006);
    cycles(4);
    bus_write(5'h00, 16'hAAAA);
    wait_req(1000, n);
    check(n == 512, "R5 code 6 -> (1+1)*256", n, 512);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_closed();
    t_open_pending();
    t_relock();
    t_refresh_idle();
    t_start_period();
    t_refresh_run();
    t_sticky();
    t_new_values();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk_i);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected 0 cycles left", WATCHDOG_CYCLES);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule